// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Register Block

This block holds the bus-master DMA control registers for a two-channel IDE controller. It also merges the two channels' interrupts onto one legacy interrupt line. A host reaches the registers through a 16-byte I/O window. Each channel has eight bytes in that window:

- a command byte;
- a status byte;
- a 32-bit descriptor-table base address.

The command byte starts and stops the channel's DMA engine and sets the transfer direction. The status byte reports that the engine is active, and it latches error and completion events. Software clears those events by writing ones to them. The block exports the start and stop requests as one-cycle strobes and drives the descriptor base out to the engine. The engine itself moves no data through this block.

The window is selected by `io_addr[3]`, which chooses the channel, and `io_addr[2]`, which chooses the command/status dword (0) or the descriptor dword (1). The byte lane comes from `io_be`. `io_addr[1:0]` is ignored.

Each channel's interrupt input sets or clears a pending flag. The two flags are ORed together. The result drives `irq_out` only while the programmable line number is non-zero. Reads are combinational and have no side effects. All writes take effect at the next rising clock edge.

Top module: `ide_bm_regs`

## Requirements
- R1: While `rst` is high, and after it is released, command, status, descriptor and pending state read as zero. `irq_line` reads 0x0E and `irq_pin` reads 0x01.
- R2: In a command/status dword, lane 0 is the command byte and lane 2 is the status byte. Single-lane reads of lanes 1 and 3 return 0xFF in that lane, and writes to lanes 1 and 3 change nothing. A single-lane read returns zero in the other lanes.
- R3: An access to a command/status dword that enables more than one lane is treated as follows:
  - a read returns 0xFF in every enabled lane and zero in the others;
  - a write changes no state and raises no strobe.
- R4: A status write handles each bit as follows:
  - bits 6:5 are loaded from the write data;
  - bits 2:1 are cleared where the data holds a 1 and kept where it holds a 0;
  - bit 0 cannot be written and shows the channel's `dma_busy` from the previous cycle;
  - bits 7, 4 and 3 always read 0.
- R5: A one-cycle `dma_err_evt` pulse sets status bit 1, and a `dma_done_evt` pulse sets status bit 2. An event wins over a write-one-to-clear in the same cycle.
- R6: Command bit 0 is start and command bit 3 is direction. All other command bits read 0. A command write that changes bit 0 from 0 to 1 raises `dma_start` for one cycle. A write that changes it from 1 to 0 raises `dma_stop` for one cycle. Rewriting the same value raises neither.
- R7: The descriptor dword is written only when all four byte enables are set. Bits 1:0 are stored as zero. Reads return the full dword, and `desc_addr` drives it out.
- R8: `irq_pend[c]` takes the value of `chan_irq[c]` at each clock edge, so it is set on a rising input and cleared on a falling input.
- R9: `irq_out` is the OR of both pending flags while `irq_line` is non-zero, and is 0 while `irq_line` is zero.
- R10: A write on `line_we` loads only the low 4 bits of `irq_line`. The upper 4 bits stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 4 | Byte address in the window |
| io_be | input | 4 | Byte-lane enables |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data (combinational) |
| dma_busy | input | 2 | Per-channel engine active |
| dma_err_evt | input | 2 | Per-channel error event pulse |
| dma_done_evt | input | 2 | Per-channel completion event pulse |
| chan_irq | input | 2 | Per-channel interrupt level |
| line_we | input | 1 | Interrupt-line register write |
| line_wdata | input | 8 | Interrupt-line write data |
| dma_start | output | 2 | One-cycle start strobe per channel |
| dma_stop | output | 2 | One-cycle stop strobe per channel |
| dma_dir | output | 2 | Transfer direction per channel |
| desc_addr | output | 64 | Descriptor base, channel 1 in the upper half |
| irq_pend | output | 2 | Per-channel interrupt pending flag |
| irq_out | output | 1 | Combined interrupt level |
| irq_line | output | 8 | Interrupt-line number |
| irq_pin | output | 8 | Interrupt-pin field, fixed at 1 |

## Verification
The clocked properties assume that every input is driven with a known value at each rising edge and that `rst` is held for at least one edge before release. The property on dropped wide writes assumes that no single-lane command write reaches the same channel in the same cycle. With only one access port this is always true. The bench changes every input on the falling edge and drives each write and each event as a single-cycle pulse. It also overlaps a write-one-to-clear with an event only in the dedicated priority scenario, so those assumptions hold throughout.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam int LANES = 4;

  // Number of byte lanes enabled.
  function automatic int unsigned lane_count(input logic [LANES-1:0] be);
    int unsigned n;
    n = 0;
    for (int i = 0; i < LANES; i++) n += {31'd0, be[i]};
    return n;
  endfunction

  // Index of the lowest enabled lane.
  function automatic logic [1:0] lane_of(input logic [LANES-1:0] be);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = LANES - 1; i >= 0; i--) if (be[i]) idx = 2'(i);
    return idx;
  endfunction

  // Next status byte: events set, write-ones clear, 6:5 loaded, 0 mirrors busy.
  function automatic logic [7:0] stat_next(input logic [7:0] cur, input logic [7:0] wd,
                                           input logic wr, input logic busy,
                                           input logic err, input logic done);
    logic [1:0] clr;
    logic [1:0] keep;
    logic [1:0] hi;
    clr  = wr ? wd[2:1] : 2'b00;
    keep = (cur[2:1] & ~clr) | {done, err};
    hi   = wr ? wd[6:5] : cur[6:5];
    return {1'b0, hi, 2'b00, keep, busy};
  endfunction

  // Descriptor base kept dword aligned.
  function automatic logic [31:0] dword_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction
endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic          stat_we,
  input  logic          desc_we,
  input  logic [7:0]    wbyte,
  input  logic [DW-1:0] wdesc,
  input  logic          busy,
  input  logic          err_evt,
  input  logic          done_evt,
  output logic [7:0]    cmd_q,
  output logic [7:0]    stat_q,
  output logic [DW-1:0] desc_q,
  output logic          start_p,
  output logic          stop_p
);
  logic go_rise, go_fall;
  assign go_rise = cmd_we &  wbyte[0] & ~cmd_q[0];
  assign go_fall = cmd_we & ~wbyte[0] &  cmd_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      desc_q  <= '0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= {4'b0000, wbyte[3], 2'b00, wbyte[0]};
      stat_q  <= stat_next(stat_q, wbyte, stat_we, busy, err_evt, done_evt);
      if (desc_we) desc_q <= DW'(dword_align(32'(wdesc)));
      start_p <= go_rise;
      stop_p  <= go_fall;
    end
  end
endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq #(
  parameter int         NCH      = 2,
  parameter logic [7:0] LINE_RST = 8'h0E
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_irq,
  input  logic           line_we,
  input  logic [7:0]     line_wdata,
  output logic [NCH-1:0] pend_q,
  output logic [7:0]     line_q,
  output logic           any_pend,
  output logic           irq_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      line_q <= LINE_RST;
    end else begin
      pend_q <= chan_irq;
      if (line_we) line_q <= {4'b0000, line_wdata[3:0]};
    end
  end

  assign any_pend = |pend_q;
  assign irq_out  = any_pend & (line_q != 8'd0);
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int         NCH      = 2,
  parameter int         DW       = 32,
  parameter logic [7:0] LINE_RST = 8'h0E,
  parameter logic [7:0] PIN_VAL  = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        io_addr,
  input  logic [3:0]        io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic [NCH-1:0]    dma_busy,
  input  logic [NCH-1:0]    dma_err_evt,
  input  logic [NCH-1:0]    dma_done_evt,
  input  logic [NCH-1:0]    chan_irq,
  input  logic              line_we,
  input  logic [7:0]        line_wdata,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    dma_stop,
  output logic [NCH-1:0]    dma_dir,
  output logic [NCH*DW-1:0] desc_addr,
  output logic [NCH-1:0]    irq_pend,
  output logic              irq_out,
  output logic [7:0]        irq_line,
  output logic [7:0]        irq_pin
);
  localparam int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CSEL_W-1:0] ch_sel;
  logic              is_desc, one_lane, all_lanes;
  logic [1:0]        lane;
  logic [7:0]        wbyte;
  logic [NCH*8-1:0]  cmd_flat, stat_flat;
  logic              any_pend;

  assign ch_sel    = CSEL_W'(io_addr[3]);
  assign is_desc   = io_addr[2];
  assign one_lane  = (lane_count(io_be) == 1);
  assign all_lanes = (io_be == 4'hF);
  assign lane      = lane_of(io_be);
  assign wbyte     = io_wdata[lane*8 +: 8];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, cmd_we, stat_we, desc_we;
    assign hit     = io_wr & (ch_sel == CSEL_W'(c));
    assign cmd_we  = hit & ~is_desc & one_lane & (lane == 2'd0);
    assign stat_we = hit & ~is_desc & one_lane & (lane == 2'd2);
    assign desc_we = hit &  is_desc & all_lanes;

    ide_bm_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst),
      .cmd_we(cmd_we), .stat_we(stat_we), .desc_we(desc_we),
      .wbyte(wbyte), .wdesc(DW'(io_wdata)),
      .busy(dma_busy[c]), .err_evt(dma_err_evt[c]), .done_evt(dma_done_evt[c]),
      .cmd_q(cmd_flat[c*8 +: 8]), .stat_q(stat_flat[c*8 +: 8]),
      .desc_q(desc_addr[c*DW +: DW]),
      .start_p(dma_start[c]), .stop_p(dma_stop[c])
    );
    assign dma_dir[c] = cmd_flat[c*8 + 3];
  end

  always_comb begin
    logic [7:0] sel_cmd, sel_stat;
    logic [DW-1:0] sel_desc;
    sel_cmd  = '0;
    sel_stat = '0;
    sel_desc = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_sel == CSEL_W'(c)) begin
        sel_cmd  = cmd_flat[c*8 +: 8];
        sel_stat = stat_flat[c*8 +: 8];
        sel_desc = desc_addr[c*DW +: DW];
      end
    end
    io_rdata = '0;
    if (io_rd) begin
      if (is_desc) begin
        io_rdata = 32'(sel_desc);
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (io_be[l]) begin
            if (!one_lane)   io_rdata[l*8 +: 8] = 8'hFF;
            else if (l == 0) io_rdata[l*8 +: 8] = sel_cmd;
            else if (l == 2) io_rdata[l*8 +: 8] = sel_stat;
            else             io_rdata[l*8 +: 8] = 8'hFF;
          end
        end
      end
    end
  end

  ide_bm_irq #(.NCH(NCH), .LINE_RST(LINE_RST)) u_irq (
    .clk(clk), .rst(rst), .chan_irq(chan_irq),
    .line_we(line_we), .line_wdata(line_wdata),
    .pend_q(irq_pend), .line_q(irq_line), .any_pend(any_pend), .irq_out(irq_out)
  );

  assign irq_pin = PIN_VAL;
endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk #(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        io_addr,
  input logic [3:0]        io_be,
  input logic              io_wr,
  input logic [NCH-1:0]    dma_busy,
  input logic [NCH-1:0]    dma_err_evt,
  input logic [NCH-1:0]    dma_done_evt,
  input logic [NCH-1:0]    chan_irq,
  input logic [NCH*8-1:0]  cmd_flat,
  input logic [NCH*8-1:0]  stat_flat,
  input logic [NCH*DW-1:0] desc_addr,
  input logic [NCH-1:0]    dma_start,
  input logic [NCH-1:0]    dma_stop,
  input logic [NCH-1:0]    irq_pend,
  input logic              irq_out,
  input logic [7:0]        irq_line
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r4_busy_mirror: assert property (@(posedge clk) disable iff (rst)
      !rst |=> stat_flat[c*8] == $past(dma_busy[c]));
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      stat_flat[c*8+7] == 1'b0 && stat_flat[c*8+4 -: 2] == 2'b00);
    a_r5_err_wins: assert property (@(posedge clk) disable iff (rst)
      (!rst && dma_err_evt[c]) |=> stat_flat[c*8+1]);
    a_r5_done_wins: assert property (@(posedge clk) disable iff (rst)
      (!rst && dma_done_evt[c]) |=> stat_flat[c*8+2]);
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
      !(dma_start[c] && dma_stop[c]));
    a_r7_desc_aligned: assert property (@(posedge clk) disable iff (rst)
      desc_addr[c*DW +: 2] == 2'b00);
  end

  a_r3_wide_drop: assert property (@(posedge clk) disable iff (rst)
    (!rst && io_wr && !io_addr[2] && $countones(io_be) > 1) |=> $stable(cmd_flat));
  a_r8_pend_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq_pend == $past(chan_irq));
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_line == 8'd0 |-> !irq_out);
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_line != 8'd0 |-> irq_out == (|irq_pend));
  a_r10_line_high: assert property (@(posedge clk) disable iff (rst)
    irq_line[7:4] == 4'd0);
endmodule

bind ide_bm_regs ide_bm_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_wr(io_wr),
  .dma_busy(dma_busy), .dma_err_evt(dma_err_evt), .dma_done_evt(dma_done_evt),
  .chan_irq(chan_irq), .cmd_flat(cmd_flat), .stat_flat(stat_flat),
  .desc_addr(desc_addr), .dma_start(dma_start), .dma_stop(dma_stop),
  .irq_pend(irq_pend), .irq_out(irq_out), .irq_line(irq_line)
);

// File: tb/ide_bm_regs_bench.sv
`timescale 1ns/1ps
module ide_bm_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] io_addr = '0, io_be = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic [1:0] dma_busy = '0, dma_err_evt = '0, dma_done_evt = '0, chan_irq = '0;
  logic line_we = 1'b0;
  logic [7:0] line_wdata = '0;
  logic [1:0] dma_start, dma_stop, dma_dir, irq_pend;
  logic [63:0] desc_addr;
  logic irq_out;
  logic [7:0] irq_line, irq_pin;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ide_bm_regs u_ide_bm_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dma_busy(dma_busy), .dma_err_evt(dma_err_evt), .dma_done_evt(dma_done_evt),
    .chan_irq(chan_irq), .line_we(line_we), .line_wdata(line_wdata),
    .dma_start(dma_start), .dma_stop(dma_stop), .dma_dir(dma_dir),
    .desc_addr(desc_addr), .irq_pend(irq_pend), .irq_out(irq_out),
    .irq_line(irq_line), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    io_addr = a; io_be = be; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    idle(1);
    rd(4'h0, 4'b0001, d); chk("R1 cmd0", 64'(d), 64'h0);
    rd(4'h8, 4'b0100, d); chk("R1 stat1", 64'(d), 64'h0);
    rd(4'h4, 4'hF, d);    chk("R1 desc0", 64'(d), 64'h0);
    chk("R1 line", 64'(irq_line), 64'h0E);
    chk("R1 pin", 64'(irq_pin), 64'h01);
    chk("R1 pend", 64'({irq_pend, irq_out}), 64'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    rd(4'h0, 4'b0010, d); chk("R2 lane1 read", 64'(d), 64'h0000FF00);
    wr(4'h0, 4'b1000, 32'hFF000000);
    wr(4'h0, 4'b0010, 32'h0000FF00);
    rd(4'h0, 4'b1000, d); chk("R2 lane3 read", 64'(d), 64'hFF000000);
    rd(4'h0, 4'b0001, d); chk("R2 cmd untouched", 64'(d), 64'h0);
    rd(4'h0, 4'b0100, d); chk("R2 stat untouched", 64'(d), 64'h0);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    wr(4'h0, 4'b0011, 32'h00000909);
    chk("R3 no strobe", 64'(dma_start), 64'h0);
    rd(4'h0, 4'b0001, d); chk("R3 write dropped", 64'(d), 64'h0);
    rd(4'h0, 4'b0011, d); chk("R3 half read", 64'(d), 64'h0000FFFF);
    rd(4'h8, 4'hF, d);    chk("R3 dword read", 64'(d), 64'hFFFFFFFF);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(4'h8, 4'b0001, 32'h000000FF);
    chk("R6 start strobe", 64'({dma_start, dma_stop}), 64'b1000);
    rd(4'h8, 4'b0001, d); chk("R6 cmd readback", 64'(d), 64'h09);
    chk("R6 dir", 64'(dma_dir), 64'b10);
    idle(1); chk("R6 strobe one cycle", 64'(dma_start), 64'h0);
    wr(4'h8, 4'b0001, 32'h00000009);
    chk("R6 no restart", 64'({dma_start, dma_stop}), 64'h0);
    wr(4'h8, 4'b0001, 32'h00000000);
    chk("R6 stop strobe", 64'({dma_start, dma_stop}), 64'b0010);
    rd(4'h8, 4'b0001, d); chk("R6 stopped", 64'(d), 64'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    dma_busy = 2'b01; idle(1);
    rd(4'h0, 4'b0100, d); chk("R4 busy mirror", 64'(d), 64'h00010000);
    wr(4'h0, 4'b0100, 32'h00FF0000);
    rd(4'h0, 4'b0100, d); chk("R4 masked write", 64'(d), 64'h00610000);
    dma_busy = 2'b00;
    wr(4'h0, 4'b0100, 32'h00000000);
    rd(4'h0, 4'b0100, d); chk("R4 bit0 follows input", 64'(d), 64'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    @(negedge clk); dma_err_evt = 2'b01; @(negedge clk); dma_err_evt = 2'b00;
    rd(4'h0, 4'b0100, d); chk("R5 err sets", 64'(d), 64'h00020000);
    @(negedge clk); dma_done_evt = 2'b01; @(negedge clk); dma_done_evt = 2'b00;
    rd(4'h0, 4'b0100, d); chk("R5 done sets", 64'(d), 64'h00060000);
    wr(4'h0, 4'b0100, 32'h00020000);
    rd(4'h0, 4'b0100, d); chk("R4 w1c bit1", 64'(d), 64'h00040000);
    @(negedge clk);
    io_addr = 4'h0; io_be = 4'b0100; io_wdata = 32'h00040000; io_wr = 1'b1;
    dma_done_evt = 2'b01;
    @(negedge clk); io_wr = 1'b0; dma_done_evt = 2'b00;
    rd(4'h0, 4'b0100, d); chk("R5 set beats clear", 64'(d), 64'h00040000);
    wr(4'h0, 4'b0100, 32'h00040000);
    rd(4'h0, 4'b0100, d); chk("R4 w1c bit2", 64'(d), 64'h0);
    rd(4'h8, 4'b0100, d); chk("R5 other channel clear", 64'(d), 64'h0);
  endtask

  task automatic t_desc();
    logic [31:0] d;
    wr(4'h4, 4'hF, 32'h12345677);
    rd(4'h4, 4'hF, d); chk("R7 aligned", 64'(d), 64'h12345674);
    wr(4'h4, 4'b0011, 32'hFFFFFFFF);
    rd(4'h4, 4'hF, d); chk("R7 partial dropped", 64'(d), 64'h12345674);
    wr(4'hC, 4'hF, 32'hABCDEF03);
    chk("R7 desc out", desc_addr, 64'hABCDEF00_12345674);
  endtask

  task automatic t_irq();
    @(negedge clk); chan_irq = 2'b10;
    #1 chk("R8 not yet", 64'(irq_pend), 64'h0);
    @(negedge clk);
    chk("R8 pend set", 64'(irq_pend), 64'b10);
    chk("R9 irq on", 64'(irq_out), 64'h1);
    chan_irq = 2'b00; @(negedge clk);
    chk("R8 pend clear", 64'({irq_pend, irq_out}), 64'h0);
  endtask

  task automatic t_line();
    @(negedge clk); line_we = 1'b1; line_wdata = 8'hF5;
    @(negedge clk); line_we = 1'b0;
    chk("R10 low nibble", 64'(irq_line), 64'h05);
    chan_irq = 2'b01; @(negedge clk);
    chk("R9 ch0 drives", 64'(irq_out), 64'h1);
    line_we = 1'b1; line_wdata = 8'h00; @(negedge clk); line_we = 1'b0;
    chk("R9 line zero gates", 64'({irq_pend, irq_out}), 64'b010);
    chan_irq = 2'b00; @(negedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_map();
    t_wide();
    t_cmd();
    t_status();
    t_events();
    t_desc();
    t_irq();
    t_line();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule